// File: doc/BRIEF.md
# Staged Display Power Sequencer

This block brings the four power domains of a display pipeline up and down in a fixed order. The four domains are the pixel clock, the sync timing generator, the panel display-enable line, and the backlight PWM. Software asks for domains through a small register-style write port. One write address sets request bits and a second address clears them. A read-only status word reports which domains are currently live, and each domain also drives its own enable output.

Power-up works as a chain. A domain comes on in the cycle after its request is held and its predecessor is both live and still requested. The display-enable line also waits a programmable number of frames after sync becomes live. Power-down waits for frame boundaries, which arrive as single-cycle pulses from the timing generator. Each frame boundary retires at most one stage, in the order display, then sync, then clock, then PWM. No domain goes dark partway through a frame. A request that arrives before its prerequisite is live stays latched and takes effect once the prerequisite comes up.

Top module: `dps_sequencer`

## Requirements
- R1: After reset the status word, the request bits and all four domain enables are 0.
- R2: A write with `wr_clr`=0 sets request bit i for every `wr_data[i]`=1. A write with `wr_clr`=1 clears request bit i for every `wr_data[i]`=1. Zero bits leave the requests unchanged. Bit 0 is the pixel clock, bit 1 sync, bit 2 display and bit 3 PWM, in both the write data and the status word.
- R3: Power-up happens in the order clock, sync, display, PWM. The clock comes on one cycle after its request is registered. Each later domain comes on one cycle after its own request is held while the previous domain's status is 1 and that domain's request is still held.
- R4: Sync status is never 1 while clock status is 0. Display status is never 1 while sync status is 0.
- R5: Display status rises only after at least `guard_frames` frame pulses have been seen while sync status was 1. With `guard_frames`=0 it may rise one cycle after sync.
- R6: A domain whose request is cleared turns off only in the cycle after a `frame_tick` pulse. Display may turn off at any pulse. Sync turns off only once display is off, clock only once sync is off, and PWM only once clock is off. So each pulse retires at most one step of that chain.
- R7: A request written while its prerequisite is off has no visible effect until the prerequisite comes up. It then completes without any further write.
- R8: Outputs `pix_clk_on`, `sync_on`, `disp_on` and `pwm_on` equal status bits 0 to 3 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_clr | input | 1 | 0 = write the set register, 1 = write the clear register |
| wr_data | input | 4 | One bit per domain; ones act, zeros are ignored |
| frame_tick | input | 1 | Single-cycle frame boundary pulse |
| guard_frames | input | GUARD_W | Frames to hold display off after sync is live |
| status | output | 4 | Read-only live state, one bit per domain |
| pix_clk_on | output | 1 | Pixel clock domain enable |
| sync_on | output | 1 | Sync timing domain enable |
| disp_on | output | 1 | Display-enable domain |
| pwm_on | output | 1 | Backlight PWM domain enable |

## Verification
The bench writes a sync request with the clock off. A design that ignored ordering would show sync live; one that dropped the latched request would never finish the bring-up. It counts frame pulses across the guard window at a non-zero setting and at zero. An off-by-one guard comparison shows up there as display rising one frame early or late. It then clears every request at once and steps single frame pulses. A design that shut domains off immediately, retired several stages per pulse, or used the wrong shutdown order would produce a different status word after some pulse than the reference model.

// File: rtl/dps_pkg.sv
package dps_pkg;

  localparam int NDOM = 4;

  localparam int D_CLK  = 0;
  localparam int D_SYNC = 1;
  localparam int D_DISP = 2;
  localparam int D_PWM  = 3;

  // Power-up gate for a stage: predecessor live and still requested.
  function automatic logic stage_up_ok(input int idx,
                                       input logic [NDOM-1:0] st,
                                       input logic [NDOM-1:0] req,
                                       input logic guard_ok);
    logic ok;
    case (idx)
      D_CLK:   ok = 1'b1;
      D_SYNC:  ok = st[D_CLK] & req[D_CLK];
      D_DISP:  ok = st[D_SYNC] & req[D_SYNC] & guard_ok;
      default: ok = st[D_DISP] & req[D_DISP];
    endcase
    return ok;
  endfunction

  // Power-down gate: chain display -> sync -> clock -> pwm.
  function automatic logic stage_down_ok(input int idx,
                                         input logic [NDOM-1:0] st);
    logic ok;
    case (idx)
      D_DISP:  ok = 1'b1;
      D_SYNC:  ok = ~st[D_DISP];
      D_CLK:   ok = ~st[D_SYNC];
      default: ok = ~st[D_CLK];
    endcase
    return ok;
  endfunction

  function automatic logic guard_met(input logic [7:0] cnt,
                                     input logic [7:0] limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/dps_req_reg.sv
module dps_req_reg
  import dps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_clr,
  input  logic [NDOM-1:0] wr_data,
  output logic [NDOM-1:0] req
);
  logic [NDOM-1:0] set_mask;
  logic [NDOM-1:0] clr_mask;

  assign set_mask = (wr_en && !wr_clr) ? wr_data : '0;
  assign clr_mask = (wr_en &&  wr_clr) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) req <= '0;
    else        req <= (req | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/dps_guard_cnt.sv
module dps_guard_cnt
  import dps_pkg::*;
#(
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_live,
  input  logic               frame_tick,
  input  logic [GUARD_W-1:0] guard_frames,
  output logic               guard_ok
);
  localparam logic [GUARD_W-1:0] CNT_MAX = {GUARD_W{1'b1}};

  logic [GUARD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !sync_live) cnt <= '0;
    else if (frame_tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign guard_ok = guard_met(8'(cnt), 8'(guard_frames));
endmodule

// File: rtl/dps_stage.sv
module dps_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic up_ok,
  input  logic dn_ok,
  input  logic frame_tick,
  output logic live,
  output logic rise_ev,
  output logic fall_ev
);
  assign rise_ev = !live && req && up_ok;
  assign fall_ev = live && !req && dn_ok && frame_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)       live <= 1'b0;
    else if (rise_ev) live <= 1'b1;
    else if (fall_ev) live <= 1'b0;
  end
endmodule

// File: rtl/dps_sequencer.sv
module dps_sequencer
  import dps_pkg::*;
#(
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_clr,
  input  logic [3:0]         wr_data,
  input  logic               frame_tick,
  input  logic [GUARD_W-1:0] guard_frames,
  output logic [3:0]         status,
  output logic               pix_clk_on,
  output logic               sync_on,
  output logic               disp_on,
  output logic               pwm_on
);
  logic [NDOM-1:0] req;
  logic [NDOM-1:0] live;
  logic [NDOM-1:0] up_ok;
  logic [NDOM-1:0] dn_ok;
  logic [NDOM-1:0] rise_ev;
  logic [NDOM-1:0] fall_ev;
  logic            guard_ok;

  dps_req_reg u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_clr  (wr_clr),
    .wr_data (wr_data),
    .req     (req)
  );

  dps_guard_cnt #(.GUARD_W(GUARD_W)) u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_live    (live[D_SYNC]),
    .frame_tick   (frame_tick),
    .guard_frames (guard_frames),
    .guard_ok     (guard_ok)
  );

  for (genvar i = 0; i < NDOM; i++) begin : g_stage
    assign up_ok[i] = stage_up_ok(i, live, req, guard_ok);
    assign dn_ok[i] = stage_down_ok(i, live);

    dps_stage u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req[i]),
      .up_ok      (up_ok[i]),
      .dn_ok      (dn_ok[i]),
      .frame_tick (frame_tick),
      .live       (live[i]),
      .rise_ev    (rise_ev[i]),
      .fall_ev    (fall_ev[i])
    );
  end

  assign status     = live;
  assign pix_clk_on = live[D_CLK];
  assign sync_on    = live[D_SYNC];
  assign disp_on    = live[D_DISP];
  assign pwm_on     = live[D_PWM];
endmodule

// File: rtl/dps_sequencer_chk.sv
module dps_sequencer_chk #(
  parameter int GUARD_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_tick,
  input logic [GUARD_W-1:0] guard_frames,
  input logic [3:0]         status,
  input logic               pix_clk_on,
  input logic               sync_on,
  input logic               disp_on,
  input logic               pwm_on
);
  localparam logic [GUARD_W-1:0] SAT = {GUARD_W{1'b1}};

  // frame pulses observed while sync has been live
  logic [GUARD_W-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n || !status[1]) seen <= '0;
    else if (frame_tick && seen != SAT) seen <= seen + 1'b1;
  end

  a_r4_sync_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]);

  a_r4_disp_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[1]);

  a_r3_sync_rise_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(status[0]));

  a_r3_pwm_rise_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(status[2]));

  a_r5_guard_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> seen >= guard_frames);

  a_r6_clk_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(frame_tick) && !$past(status[1]));

  a_r6_sync_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> $past(frame_tick) && !$past(status[2]));

  a_r6_disp_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[2]) |-> $past(frame_tick));

  a_r6_pwm_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[3]) |-> $past(frame_tick) && !$past(status[0]));

  always_comb begin
    a_r8_outputs_mirror: assert ({pwm_on, disp_on, sync_on, pix_clk_on} == status);
  end
endmodule

bind dps_sequencer dps_sequencer_chk #(.GUARD_W(GUARD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_tick   (frame_tick),
  .guard_frames (guard_frames),
  .status       (status),
  .pix_clk_on   (pix_clk_on),
  .sync_on      (sync_on),
  .disp_on      (disp_on),
  .pwm_on       (pwm_on)
);

// File: tb/tb_dps_sequencer.sv
module tb_dps_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_clr = 1'b0;
  logic [3:0]    wr_data = '0;
  logic          frame_tick = 1'b0;
  logic [GW-1:0] guard_frames = '0;
  logic [3:0]    status;
  logic          pix_clk_on, sync_on, disp_on, pwm_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_req [4];
  int m_st  [4];
  int m_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dps_sequencer #(.GUARD_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clr(wr_clr),
    .wr_data(wr_data), .frame_tick(frame_tick), .guard_frames(guard_frames),
    .status(status), .pix_clk_on(pix_clk_on), .sync_on(sync_on),
    .disp_on(disp_on), .pwm_on(pwm_on)
  );

  function automatic logic [3:0] model_word();
    logic [3:0] w;
    for (int i = 0; i < 4; i++) w[i] = (m_st[i] != 0);
    return w;
  endfunction

  // Reference model: updated at every rising edge from pre-edge values.
  always @(posedge clk) begin
    int nreq [4];
    int nst  [4];
    int nseen;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_req[i] = 0; m_st[i] = 0; end
      m_seen = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        nreq[i] = m_req[i];
        if (wr_en && wr_data[i]) nreq[i] = wr_clr ? 0 : 1;
        nst[i] = m_st[i];
        if (m_st[i] == 0 && m_req[i] != 0) begin
          // bring-up: the previous stage must be live and still wanted
          if (i == 0) nst[i] = 1;
          else if (m_st[i-1] != 0 && m_req[i-1] != 0 &&
                   (i != 2 || m_seen >= int'(guard_frames))) nst[i] = 1;
        end else if (m_st[i] != 0 && m_req[i] == 0 && frame_tick) begin
          // shutdown chain: disp, then sync, then clock, then pwm
          case (i)
            2: nst[i] = 0;
            1: if (m_st[2] == 0) nst[i] = 0;
            0: if (m_st[1] == 0) nst[i] = 0;
            default: if (m_st[0] == 0) nst[i] = 0;
          endcase
        end
      end
      nseen = m_seen;
      if (m_st[1] == 0) nseen = 0;
      else if (frame_tick && m_seen < 15) nseen = m_seen + 1;
      for (int i = 0; i < 4; i++) begin m_req[i] = nreq[i]; m_st[i] = nst[i]; end
      m_seen = nseen;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (status !== model_word()) begin
        errors++;
        $display("FAIL R3/R5/R6 per-cycle status actual=%b expected=%b at %0t",
                 status, model_word(), $time);
      end
      checks++;
      if ({pwm_on, disp_on, sync_on, pix_clk_on} !== status) begin
        errors++;
        $display("FAIL R8 enables actual=%b expected=%b",
                 {pwm_on, disp_on, sync_on, pix_clk_on}, status);
      end
    end
  end

  task automatic chk(input logic [3:0] exp, input string tag);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s status actual=%b expected=%b", tag, status, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic clr, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_clr = clr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_clr = 1'b0; wr_data = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    guard_frames = 4'd2;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(4'b0000, "R1 reset");

    // R7: sync requested with the clock off stays invisible
    write(1'b0, 4'b0010);
    idle(5);
    chk(4'b0000, "R7 sync held without clock");

    // R3: clock request releases the latched sync request
    write(1'b0, 4'b0001);
    idle(5);
    chk(4'b0011, "R3 clock then sync");

    // R5: display and pwm requested, display gated by 2 guard frames
    write(1'b0, 4'b1100);
    idle(5);
    chk(4'b0011, "R5 display held, zero frames");
    tick();
    idle(3);
    chk(4'b0011, "R5 display held, one frame");
    tick();
    idle(4);
    chk(4'b1111, "R5 display and pwm after guard");

    // R2: zero bits in either register do nothing
    write(1'b0, 4'b0000);
    write(1'b1, 4'b0000);
    idle(2);
    tick();
    idle(2);
    chk(4'b1111, "R2 zero writes ignored");

    // R6: clear all; nothing changes before a frame pulse
    write(1'b1, 4'b1111);
    idle(6);
    chk(4'b1111, "R6 no drop before frame");
    tick(); idle(2);
    chk(4'b1011, "R6 display off first");
    tick(); idle(2);
    chk(4'b1001, "R6 sync off second");
    tick(); idle(2);
    chk(4'b1000, "R6 clock off third");
    tick(); idle(2);
    chk(4'b0000, "R6 pwm off last");

    // R5 zero guard: full bring-up in one write, no frames needed
    guard_frames = 4'd0;
    write(1'b0, 4'b1111);
    idle(7);
    chk(4'b1111, "R5 zero guard bring-up");

    // R6: clearing only sync waits for display, which is still wanted
    write(1'b1, 4'b0010);
    tick(); idle(2);
    tick(); idle(2);
    chk(4'b1111, "R6 sync blocked by live display");

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule